// File: doc/BRIEF.md
# Owner-ID Hardware Mutex Bank

This block holds a bank of hardware mutexes that several processors on one chip share through their own command ports. Each lock is a 32-bit register holding the processor ID of its owner, where zero means free. A processor claims a lock by writing its own nonzero ID to the lock's register. It then reads the register back. The claim succeeded only when the value read equals its own ID. Writing zero releases the lock.

Every port carries a command channel (valid/ready) and a response channel. The block never applies back-pressure: `cmd_ready` is high in every cycle after reset, so a command is accepted in any cycle where `cmd_valid` is high. A read produces exactly one response beat, with `rsp_valid` high, in the cycle after it is accepted. The response channel has no ready signal, so the requester must take each response when it appears. Each command also carries `cmd_id`, the requester's processor ID. The block uses it only to judge release writes. A sticky flag records any release made by a processor that did not own the lock.

Top module: `idlock_bank`

## Requirements
- R1: Lock i (0 to NUM_LOCKS-1, default 32 locks) sits at byte address BASE_OFFSET + i*STRIDE (default 0x400 and 4). A write to any other address changes no lock, and a read of any other address returns 0.
- R2: After reset every lock reads 0 (free) and `rel_err` is 0.
- R3: A nonzero write to a free lock stores the full 32-bit written value as the owner. The values 1 and 0xFFFFFFFF are both valid owners.
- R4: A read accepted in cycle N gives `rsp_valid`=1 in cycle N+1 and 0 otherwise. `rsp_data` in cycle N+1 is the owner value as it stood before any write accepted in cycle N.
- R5: A nonzero write to a lock that holds a different nonzero owner is ignored, so the earlier owner keeps it. A write of the current owner's own value leaves the lock unchanged.
- R6: A zero write releases the lock (owner becomes 0) whatever the requester's `cmd_id`.
- R7: When several ports write the same lock in one cycle, only the write from the lowest-numbered port takes effect, and the others are dropped. If the lock was free and two ports claim it, port 0 wins, and the other port reads port 0's ID back.
- R8: A zero write that takes effect while `cmd_id` differs from the stored owner sets `rel_err` one cycle later. This includes releasing a lock that is already free. `rel_err` then stays at 1 until reset.
- R9: `cmd_ready` is 1 on every port in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | NUM_PORTS | Command valid, one bit per port |
| cmd_ready | output | NUM_PORTS | Command ready, always high |
| cmd_write | input | NUM_PORTS | 1 for write, 0 for read |
| cmd_addr | input | NUM_PORTS x ADDR_W | Byte address per port |
| cmd_wdata | input | NUM_PORTS x 32 | Write value: nonzero claims, zero releases |
| cmd_id | input | NUM_PORTS x 32 | Requester processor ID, used to judge releases |
| rsp_valid | output | NUM_PORTS | Read response valid |
| rsp_data | output | NUM_PORTS x 32 | Owner value read back |
| rel_err | output | 1 | Sticky flag for a release by a non-owner |

## Verification
The claim-and-read-back flow is tried with one port working alone. This separates storing a claim from refusing a second claimant. It is also tried with both ports claiming the same free lock in one cycle, where only priority decides who reads its own ID back. A read issued in the same cycle as a write tells whether the response comes from the owner before or after that write. Releases are made by the owner, by a foreign ID and on a free lock, which separates clearing the lock from setting the flag. A long mixed phase puts unmapped, misaligned and boundary addresses among the valid ones to show that unrelated locks stay untouched.

// File: rtl/idlock_pkg.sv
package idlock_pkg;
  localparam int unsigned IDL_WORD_W = 32;
  typedef logic [IDL_WORD_W-1:0] idl_word_t;
  typedef enum logic [1:0] {OP_NONE, OP_CLAIM, OP_RELEASE} idl_op_e;
endpackage

// File: rtl/idlock_decode.sv
module idlock_decode #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned BASE_OFFSET = 32'h400,
  parameter int unsigned STRIDE      = 4,
  localparam int unsigned IDX_W      = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int unsigned STRIDE_LG = $clog2(STRIDE);
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE_OFFSET);
  localparam logic [ADDR_W-1:0] MASK_A = ADDR_W'(STRIDE - 1);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(NUM_LOCKS);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] slot;

  always_comb begin
    off  = addr - BASE_A;
    slot = off >> STRIDE_LG;
    hit  = (addr >= BASE_A) && ((off & MASK_A) == '0) && (slot < CNT_A);
    idx  = IDX_W'(slot);
  end
endmodule

// File: rtl/idlock_cell.sv
module idlock_cell
  import idlock_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_PORTS-1:0]            wr_sel,
  input  logic [NUM_PORTS-1:0][IDL_WORD_W-1:0] wdata,
  input  logic [NUM_PORTS-1:0][IDL_WORD_W-1:0] wid,
  output idl_word_t                       owner,
  output logic                            mismatch
);
  idl_word_t win_data;
  idl_word_t win_id;
  idl_word_t owner_nxt;
  idl_op_e   op;

  always_comb begin
    win_data = '0;
    win_id   = '0;
    op       = OP_NONE;
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (wr_sel[p]) begin
        win_data = wdata[p];
        win_id   = wid[p];
        op       = (wdata[p] == '0) ? OP_RELEASE : OP_CLAIM;
      end
    end
  end

  always_comb begin
    owner_nxt = owner;
    mismatch  = 1'b0;
    unique case (op)
      OP_RELEASE: begin
        owner_nxt = '0;
        mismatch  = (win_id != owner);
      end
      OP_CLAIM: if (owner == '0) owner_nxt = win_data;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) owner <= '0;
    else        owner <= owner_nxt;
  end
endmodule

// File: rtl/idlock_rdport.sv
module idlock_rdport
  import idlock_pkg::*;
#(
  parameter int unsigned NUM_LOCKS = 32,
  localparam int unsigned IDX_W    = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_en,
  input  logic                             rd_hit,
  input  logic [IDX_W-1:0]                 rd_idx,
  input  logic [NUM_LOCKS-1:0][IDL_WORD_W-1:0] owners,
  output logic                             rsp_valid,
  output idl_word_t                        rsp_data
);
  idl_word_t sel;

  always_comb begin
    sel = '0;
    if (rd_hit) sel = owners[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= sel;
    end
  end
endmodule

// File: rtl/idlock_bank.sv
module idlock_bank
  import idlock_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BASE_OFFSET = 32'h400,
  parameter int unsigned STRIDE      = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_PORTS-1:0]              cmd_valid,
  output logic [NUM_PORTS-1:0]              cmd_ready,
  input  logic [NUM_PORTS-1:0]              cmd_write,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0]  cmd_addr,
  input  logic [NUM_PORTS-1:0][31:0]        cmd_wdata,
  input  logic [NUM_PORTS-1:0][31:0]        cmd_id,
  output logic [NUM_PORTS-1:0]              rsp_valid,
  output logic [NUM_PORTS-1:0][31:0]        rsp_data,
  output logic                              rel_err
);
  localparam int unsigned IDX_W = (NUM_LOCKS > 1) ? $clog2(NUM_LOCKS) : 1;

  logic [NUM_PORTS-1:0]              p_hit;
  logic [NUM_PORTS-1:0][IDX_W-1:0]   p_idx;
  logic [NUM_LOCKS-1:0][IDL_WORD_W-1:0] owner_q;
  logic [NUM_LOCKS-1:0]              lock_mism;

  assign cmd_ready = '1;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    idlock_decode #(
      .ADDR_W(ADDR_W), .NUM_LOCKS(NUM_LOCKS),
      .BASE_OFFSET(BASE_OFFSET), .STRIDE(STRIDE)
    ) u_dec (
      .addr(cmd_addr[p]), .hit(p_hit[p]), .idx(p_idx[p])
    );

    idlock_rdport #(.NUM_LOCKS(NUM_LOCKS)) u_rd (
      .clk(clk), .rst_n(rst_n),
      .rd_en(cmd_valid[p] && !cmd_write[p]),
      .rd_hit(p_hit[p]), .rd_idx(p_idx[p]),
      .owners(owner_q),
      .rsp_valid(rsp_valid[p]), .rsp_data(rsp_data[p])
    );
  end

  for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_lock
    logic [NUM_PORTS-1:0] sel;
    always_comb begin
      for (int p = 0; p < NUM_PORTS; p++)
        sel[p] = cmd_valid[p] && cmd_write[p] && p_hit[p] && (p_idx[p] == IDX_W'(k));
    end

    idlock_cell #(.NUM_PORTS(NUM_PORTS)) u_cell (
      .clk(clk), .rst_n(rst_n),
      .wr_sel(sel), .wdata(cmd_wdata), .wid(cmd_id),
      .owner(owner_q[k]), .mismatch(lock_mism[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rel_err <= 1'b0;
    else        rel_err <= rel_err || (|lock_mism);
  end
endmodule

// File: rtl/idlock_bank_chk.sv
module idlock_bank_chk #(
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned NUM_LOCKS   = 32,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned BASE_OFFSET = 32'h400,
  parameter int unsigned STRIDE      = 4
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic [NUM_PORTS-1:0]             cmd_valid,
  input logic [NUM_PORTS-1:0]             cmd_ready,
  input logic [NUM_PORTS-1:0]             cmd_write,
  input logic [NUM_PORTS-1:0][ADDR_W-1:0] cmd_addr,
  input logic [NUM_PORTS-1:0][31:0]       cmd_wdata,
  input logic [NUM_PORTS-1:0]             rsp_valid,
  input logic                             rel_err,
  input logic [NUM_LOCKS-1:0][31:0]       owner_q
);
  logic [NUM_LOCKS-1:0] p0_claim, p0_rel, any_rel;

  always_comb begin
    for (int k = 0; k < NUM_LOCKS; k++) begin
      p0_claim[k] = cmd_valid[0] && cmd_write[0] && (cmd_wdata[0] != '0) &&
                    (cmd_addr[0] == ADDR_W'(BASE_OFFSET + k * STRIDE));
      p0_rel[k]   = cmd_valid[0] && cmd_write[0] && (cmd_wdata[0] == '0) &&
                    (cmd_addr[0] == ADDR_W'(BASE_OFFSET + k * STRIDE));
      any_rel[k]  = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (cmd_valid[p] && cmd_write[p] && (cmd_wdata[p] == '0) &&
            (cmd_addr[p] == ADDR_W'(BASE_OFFSET + k * STRIDE)))
          any_rel[k] = 1'b1;
    end
  end

  for (genvar k = 0; k < NUM_LOCKS; k++) begin : g_chk
    AST_FREE_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      (p0_claim[k] && owner_q[k] == '0) |=> (owner_q[k] == $past(cmd_wdata[0]))); // R3
    AST_HELD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q[k] != '0 && !any_rel[k]) |=> $stable(owner_q[k])); // R5
    AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      p0_rel[k] |=> (owner_q[k] == '0)); // R6
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rsp
    AST_RSP_FOLLOWS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid[p] && !cmd_write[p]) |=> rsp_valid[p]); // R4
    AST_RSP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid[p] && !cmd_write[p]) |=> !rsp_valid[p]); // R4
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |=> rel_err); // R8
  AST_ALWAYS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready == '1); // R9
endmodule

bind idlock_bank idlock_bank_chk #(
  .NUM_PORTS(NUM_PORTS), .NUM_LOCKS(NUM_LOCKS), .ADDR_W(ADDR_W),
  .BASE_OFFSET(BASE_OFFSET), .STRIDE(STRIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
  .rsp_valid(rsp_valid), .rel_err(rel_err), .owner_q(owner_q)
);

// File: tb/tb_idlock_bank.sv
module tb_idlock_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NL = 32;
  localparam int AW = 32;
  localparam longint BASE = 32'h400;
  localparam longint STR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] cmd_valid, cmd_ready, cmd_write, rsp_valid;
  logic [NP-1:0][AW-1:0] cmd_addr;
  logic [NP-1:0][31:0] cmd_wdata, cmd_id, rsp_data;
  logic rel_err;

  idlock_bank dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .cmd_id(cmd_id), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rel_err(rel_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int miscompares = 0;
  logic [31:0] m_owner [NL];
  bit          m_err;
  bit          e_rv [NP];
  logic [31:0] e_rd [NP];

  function automatic int lock_of(logic [AW-1:0] a);
    longint off;
    if (longint'(a) < BASE) return -1;
    off = longint'(a) - BASE;
    if (off % STR != 0) return -1;
    if (off / STR >= NL) return -1;
    return int'(off / STR);
  endfunction

  function automatic logic [AW-1:0] adr(int k);
    return AW'(BASE + k * STR);
  endfunction

  task automatic idle_all();
    cmd_valid = '0; cmd_write = '0; cmd_addr = '0; cmd_wdata = '0; cmd_id = '0;
  endtask

  task automatic set_op(int p, bit wr, logic [AW-1:0] a, logic [31:0] d, logic [31:0] id);
    cmd_valid[p] = 1'b1; cmd_write[p] = wr; cmd_addr[p] = a;
    cmd_wdata[p] = d; cmd_id[p] = id;
  endtask

  task automatic compare(string tag);
    for (int p = 0; p < NP; p++) begin
      vectors++;
      if (rsp_valid[p] !== e_rv[p] || (e_rv[p] && rsp_data[p] !== e_rd[p])) begin
        miscompares++;
        $display("FAIL %s port%0d rsp: actual v=%0b d=%h expected v=%0b d=%h",
                 tag, p, rsp_valid[p], rsp_data[p], e_rv[p], e_rd[p]);
      end
    end
    vectors++;
    if (rel_err !== m_err || cmd_ready !== '1) begin
      miscompares++;
      $display("FAIL %s rel_err/ready: actual %0b/%b expected %0b/11", tag, rel_err, cmd_ready, m_err);
    end
  endtask

  // Model one clock for the inputs now on the pins, then compare after the edge.
  task automatic step(string tag);
    bit touched [NL];
    int k;
    for (int i = 0; i < NL; i++) touched[i] = 0;
    for (int p = 0; p < NP; p++) begin
      e_rv[p] = cmd_valid[p] && !cmd_write[p];
      k = lock_of(cmd_addr[p]);
      if (e_rv[p]) e_rd[p] = (k >= 0) ? m_owner[k] : 32'h0;
    end
    for (int p = 0; p < NP; p++) begin
      k = lock_of(cmd_addr[p]);
      if (cmd_valid[p] && cmd_write[p] && k >= 0 && !touched[k]) begin
        touched[k] = 1;
        if (cmd_wdata[p] == 0) begin
          if (cmd_id[p] != m_owner[k]) m_err = 1;
          m_owner[k] = 0;
        end else if (m_owner[k] == 0) begin
          m_owner[k] = cmd_wdata[p];
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare(tag);
    idle_all();
  endtask

  task automatic read_lock(int p, int k, string tag);
    set_op(p, 0, adr(k), 0, 0);
    step(tag);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : stim
    logic [31:0] vals [5];
    vals[0] = 32'h0; vals[1] = 32'h1; vals[2] = 32'h2;
    vals[3] = 32'hFFFF_FFFF; vals[4] = 32'h3;
    idle_all();
    for (int i = 0; i < NL; i++) m_owner[i] = 0;
    m_err = 0;
    for (int p = 0; p < NP; p++) begin e_rv[p] = 0; e_rd[p] = 0; end
    repeat (3) @(negedge clk);
    compare("R2 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    // R2: every lock free after reset
    for (int k = 0; k < NL; k++) read_lock(k % NP, k, "R2");

    // R3: claim with ID 1, read back; R4: same-cycle read sees old value
    set_op(1, 1, adr(3), 32'h1, 32'h1);
    set_op(0, 0, adr(3), 0, 0);
    step("R4 same-cycle read");
    read_lock(1, 3, "R3 id 1");
    // R5: foreign claim ignored, same-value rewrite harmless
    set_op(0, 1, adr(3), 32'h2, 32'h2); step("R5 foreign claim");
    read_lock(0, 3, "R5");
    set_op(1, 1, adr(3), 32'h1, 32'h1); step("R5 reclaim");
    read_lock(1, 3, "R5");
    // R7: both ports claim free lock 5 together
    set_op(0, 1, adr(5), 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    set_op(1, 1, adr(5), 32'h2, 32'h2);
    step("R7 race");
    read_lock(1, 5, "R7 loser readback");
    // R7: port1 claim vs port0 release on same held lock
    set_op(0, 1, adr(5), 32'h0, 32'hFFFF_FFFF);
    set_op(1, 1, adr(5), 32'h2, 32'h2);
    step("R7 release beats claim");
    read_lock(0, 5, "R7");
    // R6 / R8: owner release leaves flag clear, foreign release sets it
    set_op(1, 1, adr(3), 32'h0, 32'h1); step("R6 owner release");
    read_lock(0, 3, "R6");
    set_op(0, 1, adr(NL-1), 32'h7, 32'h7); step("R1 last lock");
    read_lock(1, NL-1, "R1 last lock");
    set_op(1, 1, adr(NL-1), 32'h0, 32'h9); step("R8 foreign release");
    read_lock(0, NL-1, "R6 foreign release clears");
    step("R8 sticky");
    // R1: unmapped addresses
    set_op(0, 1, AW'(BASE + 2), 32'h5, 32'h5); step("R1 misaligned");
    set_op(1, 1, AW'(BASE + NL * STR), 32'h5, 32'h5); step("R1 past end");
    set_op(0, 1, AW'(BASE - STR), 32'h5, 32'h5); step("R1 below base");
    set_op(0, 0, AW'(BASE + 2), 0, 0); set_op(1, 0, AW'(BASE - STR), 0, 0);
    step("R1 unmapped read");
    read_lock(0, 0, "R1 lock 0"); read_lock(1, 1, "R1 lock 1");

    // Mixed traffic
    for (int n = 0; n < 4000; n++) begin
      for (int p = 0; p < NP; p++) begin
        int r = $urandom_range(0, 9);
        int k = ($urandom_range(0, 7) == 0) ? NL - 1 : $urandom_range(0, 3);
        logic [AW-1:0] a = adr(k);
        if ($urandom_range(0, 15) == 0) a = AW'(BASE + k * STR + 1);
        if (r < 4) set_op(p, 0, a, 0, 0);
        else if (r < 9) set_op(p, 1, a, vals[$urandom_range(0, 4)], vals[$urandom_range(1, 4)]);
      end
      step("RMIX");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule